// File: doc/BRIEF.md
# Digital Linear Ramp Generator

This block sweeps one control word of a direct digital synthesizer in straight-line steps between two programmable bounds. The swept word can feed the frequency tuning input, the phase offset input or the amplitude scale input of the synthesizer core. A tag output names which one. The block keeps an upper and a lower bound. It has separate step sizes for rising and falling, and separate rate dividers for each direction, so a sweep can climb quickly and fall slowly, or the other way round.

Two flags decide how the sweep behaves. With both flags set, the block bounces between the bounds for as long as it is enabled and ignores the direction pin. With any other combination, each change of level on the direction pin starts one ramp toward the bound that the new level selects. The ramp then stops there. A flag can make the stop a jump to the opposite bound instead of a hold.

All settings arrive on a one-cycle register-write port. A one-cycle pulse marks every arrival at a bound.

Top module: `lin_ramp_gen`

## Requirements
- R1: After reset, all settings are zero, the generator is disabled, `ramp_word` is 0, `ramp_dest` is 0 and `limit_hit` is 0.
- R2: Writes take effect on the clock edge where `cfg_we` is high. The `cfg_addr` map is: 0 upper bound, 1 lower bound, 2 rising step, 3 falling step, 4 dividers (bits 15:0 rising, bits 31:16 falling), 5 control. The control word is laid out as follows: bits 1:0 are the destination, bit 2 is the jump-at-top flag, bit 3 is the jump-at-bottom flag and bit 4 is enable. While enable is 0, the ramp value is reloaded from the lower bound on every edge, the direction pin has no effect and `limit_hit` stays 0.
- R3: While running, the value moves once every 4 × D clock cycles. D is the divider of the current direction, and a divider of 0 counts as 1. The rate counter restarts when the generator is enabled, when a single ramp starts, and after every step.
- R4: A rising step adds the rising step size. If the sum would reach or pass the upper bound, the value becomes the upper bound instead and `limit_hit` is high for exactly one cycle.
- R5: A falling step subtracts the falling step size. If the result would reach or pass the lower bound, the value becomes the lower bound instead and `limit_hit` is high for exactly one cycle.
- R6: With both flags set, the sweep rises until it hits the upper bound, then falls until it hits the lower bound, and repeats. It starts rising from the lower bound when enabled and ignores the direction pin.
- R7: With any other flag setting, a change of level on the direction pin starts one ramp: rising if the pin went to 1, falling if it went to 0. When the ramp arrives at its bound, the value stays there until the next pin change. With no pin change, the value does not move.
- R8: In single-ramp operation with the jump-at-top flag set, a rising ramp that arrives at the upper bound loads the lower bound and stops there.
- R9: In single-ramp operation with the jump-at-bottom flag set, a falling ramp that arrives at the lower bound loads the upper bound and stops there.
- R10: `ramp_dest` repeats the destination field. The destination codes are 0 frequency, 1 phase, 2 amplitude and 3 frequency. `ramp_word` is the full 32-bit value for frequency. For phase, only the top 16 bits are kept and the rest are zero. For amplitude, only the top 14 bits are kept and the rest are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| dir_pin | input | 1 | Ramp direction control (1 rising, 0 falling) |
| ramp_word | output | 32 | Current ramp value, masked for the destination |
| ramp_dest | output | 2 | Destination tag |
| limit_hit | output | 1 | One-cycle pulse on arrival at a bound |

## Verification
Bound crossings that are not a whole number of steps are driven on purpose. A design that stepped past a bound, or compared with strict inequality, would show a value beyond the bound or miss the `limit_hit` pulse. The rise and fall dividers are set to different values. A design that used one divider for both directions, or that did not restart the count on a pin change, would step one or more cycles early or late against the reference model. The pin is toggled during bounce operation and left still during single ramps. A design that listened to the pin in bounce mode, or that kept stepping after a dwell, would leave the expected trace. The jump flags are tested one at a time, so a swapped pair of flags would land the value on the wrong bound.

// File: rtl/lin_ramp_pkg.sv
package lin_ramp_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_UPPER   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOWER   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STEP_UP = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STEP_DN = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RATE    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd5;

  localparam int CTL_NDH = 2;
  localparam int CTL_NDL = 3;
  localparam int CTL_EN  = 4;

  typedef enum logic [1:0] {
    DST_FREQ  = 2'b00,
    DST_PHASE = 2'b01,
    DST_AMPL  = 2'b10,
    DST_RSVD  = 2'b11
  } ramp_dest_e;

  typedef struct packed {
    logic       en;
    logic       nd_hi;
    logic       nd_lo;
    ramp_dest_e dest;
  } ramp_ctrl_t;

endpackage

// File: rtl/lin_ramp_cfg.sv
module lin_ramp_cfg import lin_ramp_pkg::*; #(
  parameter int ACC_W = 32,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACC_W-1:0]  wdata,
  output logic [ACC_W-1:0]  lim_hi,
  output logic [ACC_W-1:0]  lim_lo,
  output logic [ACC_W-1:0]  step_up,
  output logic [ACC_W-1:0]  step_dn,
  output logic [DIV_W-1:0]  div_up,
  output logic [DIV_W-1:0]  div_dn,
  output ramp_ctrl_t        ctrl
);

  logic [ACC_W-1:0] lim_hi_d, lim_lo_d, step_up_d, step_dn_d;
  logic [DIV_W-1:0] div_up_d, div_dn_d;
  ramp_ctrl_t       ctrl_d;

  always_comb begin
    lim_hi_d  = lim_hi;
    lim_lo_d  = lim_lo;
    step_up_d = step_up;
    step_dn_d = step_dn;
    div_up_d  = div_up;
    div_dn_d  = div_dn;
    ctrl_d    = ctrl;
    if (we) begin
      case (addr)
        ADR_UPPER:   lim_hi_d  = wdata;
        ADR_LOWER:   lim_lo_d  = wdata;
        ADR_STEP_UP: step_up_d = wdata;
        ADR_STEP_DN: step_dn_d = wdata;
        ADR_RATE: begin
          div_up_d = wdata[DIV_W-1:0];
          div_dn_d = wdata[2*DIV_W-1:DIV_W];
        end
        ADR_CTRL: begin
          ctrl_d.en    = wdata[CTL_EN];
          ctrl_d.nd_hi = wdata[CTL_NDH];
          ctrl_d.nd_lo = wdata[CTL_NDL];
          ctrl_d.dest  = ramp_dest_e'(wdata[1:0]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_hi  <= '0;
      lim_lo  <= '0;
      step_up <= '0;
      step_dn <= '0;
      div_up  <= '0;
      div_dn  <= '0;
      ctrl    <= '{en: 1'b0, nd_hi: 1'b0, nd_lo: 1'b0, dest: DST_FREQ};
    end else if (we) begin
      lim_hi  <= lim_hi_d;
      lim_lo  <= lim_lo_d;
      step_up <= step_up_d;
      step_dn <= step_dn_d;
      div_up  <= div_up_d;
      div_dn  <= div_dn_d;
      ctrl    <= ctrl_d;
    end
  end

endmodule

// File: rtl/lin_ramp_tick.sv
module lin_ramp_tick #(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam int CNT_W = DIV_W + $clog2(PRESCALE + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, period_m1;
  logic [DIV_W-1:0] div_eff;

  assign div_eff   = (div == '0) ? DIV_W'(1) : div;
  assign period_m1 = CNT_W'(div_eff) * CNT_W'(PRESCALE) - CNT_W'(1);
  assign tick      = active && (cnt_q >= period_m1);

  always_comb begin
    if (!active || restart || tick) cnt_d = '0;
    else                            cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lin_ramp_core.sv
module lin_ramp_core #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             nd_hi,
  input  logic             nd_lo,
  input  logic [ACC_W-1:0] lim_hi,
  input  logic [ACC_W-1:0] lim_lo,
  input  logic [ACC_W-1:0] step_up,
  input  logic [ACC_W-1:0] step_dn,
  input  logic             pin,
  input  logic             tick,
  output logic [ACC_W-1:0] acc,
  output logic             dir_up,
  output logic             running,
  output logic             pin_edge,
  output logic             hit
);

  logic             bounce;
  logic             pin_q;
  logic [ACC_W-1:0] acc_d;
  logic             dir_d, run_d, hit_d;
  logic [ACC_W:0]   sum_up, floor_dn;
  logic             top_reached, bot_reached;

  assign bounce      = nd_hi && nd_lo;
  assign pin_edge    = pin ^ pin_q;
  assign sum_up      = {1'b0, acc} + {1'b0, step_up};
  assign floor_dn    = {1'b0, lim_lo} + {1'b0, step_dn};
  assign top_reached = sum_up >= {1'b0, lim_hi};
  assign bot_reached = {1'b0, acc} <= floor_dn;

  always_comb begin
    acc_d = acc;
    dir_d = dir_up;
    run_d = running;
    hit_d = 1'b0;
    if (!en) begin
      acc_d = lim_lo;
      dir_d = 1'b1;
      run_d = 1'b0;
    end else if (!bounce && pin_edge) begin
      dir_d = pin;
      run_d = 1'b1;
    end else if (tick) begin
      if (dir_up) begin
        if (top_reached) begin
          hit_d = 1'b1;
          run_d = 1'b0;
          if (bounce) begin
            acc_d = lim_hi;
            dir_d = 1'b0;
          end else begin
            acc_d = nd_hi ? lim_lo : lim_hi;
          end
        end else begin
          acc_d = sum_up[ACC_W-1:0];
        end
      end else begin
        if (bot_reached) begin
          hit_d = 1'b1;
          run_d = 1'b0;
          if (bounce) begin
            acc_d = lim_lo;
            dir_d = 1'b1;
          end else begin
            acc_d = nd_lo ? lim_hi : lim_lo;
          end
        end else begin
          acc_d = acc - step_dn;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      dir_up  <= 1'b1;
      running <= 1'b0;
      hit     <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      acc     <= acc_d;
      dir_up  <= dir_d;
      running <= run_d;
      hit     <= hit_d;
      pin_q   <= pin;
    end
  end

endmodule

// File: rtl/lin_ramp_gen.sv
module lin_ramp_gen import lin_ramp_pkg::*; #(
  parameter int ACC_W    = 32,
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 4,
  parameter int PH_W     = 16,
  parameter int AM_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ACC_W-1:0]  cfg_wdata,
  input  logic              dir_pin,
  output logic [ACC_W-1:0]  ramp_word,
  output logic [1:0]        ramp_dest,
  output logic              limit_hit
);

  localparam logic [ACC_W-1:0] PH_MASK = {{PH_W{1'b1}}, {(ACC_W-PH_W){1'b0}}};
  localparam logic [ACC_W-1:0] AM_MASK = {{AM_W{1'b1}}, {(ACC_W-AM_W){1'b0}}};

  logic [ACC_W-1:0] lim_hi, lim_lo, step_up, step_dn, acc;
  logic [DIV_W-1:0] div_up, div_dn, div_cur;
  ramp_ctrl_t       ctrl_q;
  logic             ramp_en, bounce, dir_up, running, pin_edge, tick;
  logic             tick_active, tick_restart;

  lin_ramp_cfg #(.ACC_W(ACC_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .step_up(step_up), .step_dn(step_dn),
    .div_up(div_up), .div_dn(div_dn), .ctrl(ctrl_q)
  );

  assign ramp_en      = ctrl_q.en;
  assign bounce       = ctrl_q.nd_hi && ctrl_q.nd_lo;
  assign div_cur      = dir_up ? div_up : div_dn;
  assign tick_active  = ramp_en && (bounce || running);
  assign tick_restart = ramp_en && !bounce && pin_edge;

  lin_ramp_tick #(.DIV_W(DIV_W), .PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .active(tick_active), .restart(tick_restart),
    .div(div_cur), .tick(tick)
  );

  lin_ramp_core #(.ACC_W(ACC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .en(ramp_en), .nd_hi(ctrl_q.nd_hi),
    .nd_lo(ctrl_q.nd_lo), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .step_up(step_up), .step_dn(step_dn), .pin(dir_pin), .tick(tick),
    .acc(acc), .dir_up(dir_up), .running(running), .pin_edge(pin_edge),
    .hit(limit_hit)
  );

  always_comb begin
    case (ctrl_q.dest)
      DST_PHASE: ramp_word = acc & PH_MASK;
      DST_AMPL:  ramp_word = acc & AM_MASK;
      default:   ramp_word = acc;
    endcase
  end

  assign ramp_dest = ctrl_q.dest;

endmodule

// File: rtl/lin_ramp_gen_chk.sv
module lin_ramp_gen_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] lim_hi,
  input logic [ACC_W-1:0] lim_lo,
  input logic             limit_hit
);

  // R2: a disabled generator reloads the lower bound
  a_r2_reload_lower: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == $past(lim_lo)));

  // R2: no bound pulse while disabled
  a_r2_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !limit_hit);

  // R3: the value only moves on a rate tick
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(acc));

  // R4 / R5: a pulse coincides with the value sitting on a bound
  a_r4_hit_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |-> (acc == $past(lim_hi) || acc == $past(lim_lo)));

  // R5: the pulse lasts one cycle
  a_r5_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> !limit_hit);

endmodule

bind lin_ramp_gen lin_ramp_gen_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ramp_en), .tick(tick), .acc(acc),
  .lim_hi(lim_hi), .lim_lo(lim_lo), .limit_hit(limit_hit)
);

// File: tb/lin_ramp_gen_bench.sv
module lin_ramp_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        dir_pin;
  logic [31:0] ramp_word;
  logic [1:0]  ramp_dest;
  logic        limit_hit;

  int    errors;
  int    checks;
  int    hit_cnt;
  string cur_req;
  bit    model_on;
  bit    done;

  lin_ramp_gen u_lin_ramp_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dir_pin(dir_pin), .ramp_word(ramp_word),
    .ramp_dest(ramp_dest), .limit_hit(limit_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference state
  longint m_hi, m_lo, m_su, m_sd, m_acc;
  int     m_du, m_dd, m_dest, m_cnt;
  bit     m_en, m_ndh, m_ndl, m_dir, m_run, m_pinq, m_hit;

  function automatic longint shaped(longint v, int d);
    if (d == 1) return v & 64'hFFFF_0000;
    if (d == 2) return v & 64'hFFFC_0000;
    return v;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit     bnc, edg, act, tk;
    int     dv, per;
    longint n_acc;
    bit     n_dir, n_run, n_hit;
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; m_su = 0; m_sd = 0; m_acc = 0;
      m_du = 0; m_dd = 0; m_dest = 0; m_cnt = 0;
      m_en = 0; m_ndh = 0; m_ndl = 0; m_dir = 1; m_run = 0; m_pinq = 0; m_hit = 0;
    end else begin
      if (limit_hit) hit_cnt++;
      bnc = m_ndh && m_ndl;
      edg = (dir_pin != m_pinq);
      dv  = m_dir ? m_du : m_dd;
      if (dv == 0) dv = 1;
      per = 4 * dv;
      act = m_en && (bnc || m_run);
      tk  = act && (m_cnt >= per - 1);
      n_acc = m_acc; n_dir = m_dir; n_run = m_run; n_hit = 0;
      if (!m_en) begin
        n_acc = m_lo; n_dir = 1; n_run = 0;
      end else if (!bnc && edg) begin
        n_dir = dir_pin; n_run = 1;
      end else if (tk) begin
        if (m_dir) begin
          if (m_acc + m_su >= m_hi) begin
            n_hit = 1; n_run = 0;
            if (bnc) begin n_acc = m_hi; n_dir = 0; end
            else n_acc = m_ndh ? m_lo : m_hi;
          end else n_acc = m_acc + m_su;
        end else begin
          if (m_acc <= m_lo + m_sd) begin
            n_hit = 1; n_run = 0;
            if (bnc) begin n_acc = m_lo; n_dir = 1; end
            else n_acc = m_ndl ? m_hi : m_lo;
          end else n_acc = m_acc - m_sd;
        end
      end
      if (!act || (m_en && !bnc && edg) || tk) m_cnt = 0;
      else m_cnt++;
      m_acc = n_acc; m_dir = n_dir; m_run = n_run; m_hit = n_hit;
      m_pinq = dir_pin;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_hi = longint'(cfg_wdata);
          3'd1: m_lo = longint'(cfg_wdata);
          3'd2: m_su = longint'(cfg_wdata);
          3'd3: m_sd = longint'(cfg_wdata);
          3'd4: begin m_du = int'(cfg_wdata[15:0]); m_dd = int'(cfg_wdata[31:16]); end
          3'd5: begin
            m_dest = int'(cfg_wdata[1:0]); m_ndh = cfg_wdata[2];
            m_ndl = cfg_wdata[3]; m_en = cfg_wdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !done) begin
      check(cur_req, longint'(ramp_word), shaped(m_acc, m_dest));
      check(cur_req, longint'(limit_hit), longint'(m_hit));
      check(cur_req, longint'(ramp_dest), longint'(m_dest));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ndh, input bit ndl,
                                      input logic [1:0] dst);
    return {27'd0, en, ndl, ndh, dst};
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int h0;
    errors = 0; checks = 0; hit_cnt = 0; cur_req = "R1";
    model_on = 0; done = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; dir_pin = 1'b0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(1);
    model_on = 1;
    check("R1", longint'(ramp_word), 0);
    check("R1", longint'(ramp_dest), 0);
    check("R1", longint'(limit_hit), 0);

    // destination masking
    cur_req = "R10";
    cfg_write(3'd1, 32'h1237_5678);
    cfg_write(3'd5, ctl(0, 0, 0, 2'd1));
    wait_n(1);
    check("R10", longint'(ramp_word), 64'h1237_0000);
    check("R10", longint'(ramp_dest), 1);
    cfg_write(3'd5, ctl(0, 0, 0, 2'd2));
    wait_n(1);
    check("R10", longint'(ramp_word), 64'h1234_0000);
    cfg_write(3'd5, ctl(0, 0, 0, 2'd3));
    wait_n(1);
    check("R10", longint'(ramp_word), 64'h1237_5678);
    cfg_write(3'd5, ctl(0, 0, 0, 2'd0));

    // disabled: pin ignored, lower bound reloaded
    cur_req = "R2";
    h0 = hit_cnt;
    dir_pin = 1'b1; wait_n(3);
    dir_pin = 1'b0; wait_n(3);
    check("R2", longint'(ramp_word), 64'h1237_5678);
    check("R2", longint'(hit_cnt - h0), 0);
    cfg_write(3'd1, 32'd50);
    wait_n(1);
    check("R2", longint'(ramp_word), 50);

    // step timing with separate dividers
    cur_req = "R3";
    cfg_write(3'd1, 32'd100);
    cfg_write(3'd0, 32'd1000);
    cfg_write(3'd2, 32'd10);
    cfg_write(3'd3, 32'd7);
    cfg_write(3'd4, {16'd2, 16'd3});
    cfg_write(3'd5, ctl(1, 1, 1, 2'd0));
    wait_n(11);
    check("R3", longint'(ramp_word), 100);
    wait_n(1);
    check("R3", longint'(ramp_word), 110);
    wait_n(11);
    check("R3", longint'(ramp_word), 110);
    wait_n(1);
    check("R3", longint'(ramp_word), 120);
    cfg_write(3'd5, ctl(0, 0, 0, 2'd0));
    cfg_write(3'd0, 32'd120);
    cfg_write(3'd5, ctl(1, 0, 0, 2'd0));
    dir_pin = 1'b1;
    wait_n(40);
    check("R3", longint'(ramp_word), 120);
    dir_pin = 1'b0;
    wait_n(8);
    check("R3", longint'(ramp_word), 120);
    wait_n(1);
    check("R3", longint'(ramp_word), 113);

    // saturation at the top, dwell, saturation at the bottom
    cur_req = "R4";
    cfg_write(3'd5, ctl(0, 0, 0, 2'd0));
    cfg_write(3'd1, 32'd0);
    cfg_write(3'd0, 32'd25);
    cfg_write(3'd3, 32'd10);
    cfg_write(3'd4, {16'd1, 16'd1});
    cfg_write(3'd5, ctl(1, 0, 0, 2'd0));
    h0 = hit_cnt;
    dir_pin = 1'b1;
    wait_n(20);
    check("R4", longint'(ramp_word), 25);
    check("R4", longint'(hit_cnt - h0), 1);
    cur_req = "R7";
    wait_n(40);
    check("R7", longint'(ramp_word), 25);
    check("R7", longint'(hit_cnt - h0), 1);
    cur_req = "R5";
    dir_pin = 1'b0;
    wait_n(20);
    check("R5", longint'(ramp_word), 0);
    check("R5", longint'(hit_cnt - h0), 2);
    cur_req = "R7";
    wait_n(40);
    check("R7", longint'(ramp_word), 0);

    // jump at the top
    cur_req = "R8";
    cfg_write(3'd5, ctl(1, 1, 0, 2'd0));
    h0 = hit_cnt;
    dir_pin = 1'b1;
    wait_n(9);
    check("R8", longint'(ramp_word), 20);
    wait_n(12);
    check("R8", longint'(ramp_word), 0);
    check("R8", longint'(hit_cnt - h0), 1);

    // jump at the bottom
    cur_req = "R9";
    cfg_write(3'd5, ctl(1, 0, 1, 2'd0));
    h0 = hit_cnt;
    dir_pin = 1'b0;
    wait_n(5);
    check("R9", longint'(ramp_word), 25);
    wait_n(20);
    check("R9", longint'(ramp_word), 25);
    check("R9", longint'(hit_cnt - h0), 1);

    // bounce sweep with the pin toggling
    cur_req = "R6";
    cfg_write(3'd5, ctl(0, 0, 0, 2'd0));
    cfg_write(3'd1, 32'd100);
    cfg_write(3'd0, 32'd140);
    cfg_write(3'd2, 32'd10);
    cfg_write(3'd3, 32'd20);
    cfg_write(3'd5, ctl(1, 1, 1, 2'd0));
    h0 = hit_cnt;
    for (int i = 0; i < 40; i++) begin
      dir_pin = ~dir_pin;
      wait_n(6);
    end
    check("R6", longint'((hit_cnt - h0) >= 19 && (hit_cnt - h0) <= 21), 1);

    finish_run();
  end

endmodule